// File: doc/BRIEF.md
# Multi-channel timer register wrapper

This block is the bus-facing shell around two or three independent timer channels. It takes single-cycle register requests carrying a byte address. It decodes each request into one of two shared registers or into the register window of one channel. Reads and writes are forwarded to the selected channel over a simple lane interface. One shared register drives a run/stop level into each channel. The other is an optional one-bit output-control register. Every request gets a response one cycle later, carrying read data and an error flag.

Channel counting is not done here. The surrounding design attaches one counter channel per lane. Each lane reads back its registers combinationally in the request cycle and receives a run level, a capture-enable strap and an external-clock strap. Each channel raises its own interrupt, and this block routes it through. The `THREE_CH` parameter selects whether the third, capture-capable lane exists. `HAS_OCR` selects whether the output-control register exists.

Top module: `tmu_wrap`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_err`, `rsp_rdata`, `ch_run` and `out_ctl` are all 0.
- R2: A request (`req_valid` high) at one clock edge produces `rsp_valid` high for exactly the following cycle. No response appears without a request.
- R3: When `HAS_OCR` is set, byte offset 0x00 holds the output-control register. Only write-data bit 0 is stored; it drives `out_ctl` from the cycle after the write and reads back zero-extended. When `HAS_OCR` is clear, offset 0x00 is an invalid address.
- R4: Byte offset 0x04 is the run register. Bit n drives `ch_run[n]` (1 = running, 0 = stopped) from the cycle after the write. A read returns the stored bits, masked to the implemented lanes, with all other bits 0.
- R5: Each lane has a window of word-aligned addresses: lane 0 covers 0x08–0x13, lane 1 covers 0x14–0x1F and lane 2 covers 0x20–0x2F. Lane 2's fourth word, at 0x2C, is its capture register. Within a window, `ch_sel` is one-hot for that lane in the request cycle, and `ch_word` = (address − window base) / 4. `ch_write` mirrors `req_write`, and `ch_wdata` carries the write data. A read returns that lane's `ch_rdata` slice (lane n at bits n*DATA_W upward).
- R6: `ch_cap_en` is high only for lane 2, and only when `THREE_CH` is set. `ch_ext_clk` equals the `EXT_CLK` parameter for every implemented lane and is 0 for absent lanes.
- R7: With `THREE_CH` clear, every address from 0x20 upward is invalid, lane 2 is never selected, and `ch_run[2]` stays 0.
- R8: With `THREE_CH` clear, a write to 0x04 with bit 2 set is flagged with `rsp_err` and leaves the whole run register unchanged.
- R9: An invalid access (misaligned address, an address past the last window, or an absent register) selects no lane. A read returns 0, and a write changes no state. `rsp_err` is high in the response cycle.
- R10: `irq[n]` follows `ch_irq[n]` for implemented lanes and is 0 for absent lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one access per high cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the unit |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | DATA_W | Read data, 0 for writes and errors |
| rsp_err | output | 1 | Previous request was invalid |
| out_ctl | output | 1 | Stored output-control bit |
| ch_run | output | 3 | Run level per lane |
| ch_sel | output | 3 | One-hot lane select, request cycle |
| ch_write | output | 1 | Write strobe towards the selected lane |
| ch_word | output | 2 | Word index inside the lane window |
| ch_wdata | output | DATA_W | Write data towards the lanes |
| ch_rdata | input | 3*DATA_W | Combinational read data from each lane |
| ch_irq | input | 3 | Interrupt request from each lane |
| irq | output | 3 | Interrupt line per lane |
| ch_cap_en | output | 3 | Capture feature strap per lane |
| ch_ext_clk | output | 3 | External-clock feature strap per lane |

## Verification
A wrong decode shows in the request cycle itself: the wrong `ch_sel` bit, a stale `ch_word`, or a write strobe on an invalid address. A sweep over every address of both configurations catches it at once. A corrupted run or output-control register shows on `ch_run` or `out_ctl` one cycle after the offending write, and again on the next read of that register. Faults in the error path show on `rsp_err` or in nonzero data one cycle after the access.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

   // Number of lanes the port list is sized for.
   localparam int CH_MAX         = 3;
   // Word indices (byte offset / 4) of the shared registers.
   localparam int OCR_WORD       = 0;
   localparam int START_WORD     = 1;
   // First word of lane 0 and the stride between lane windows, in words.
   localparam int FIRST_LANE_WORD = 2;
   localparam int LANE_STRIDE_W   = 3;
   // Window sizes in words; only the capture lane has the extra word.
   localparam int LANE_WORDS_STD = 3;
   localparam int LANE_WORDS_CAP = 4;
   localparam int CAP_LANE       = 2;

   typedef enum logic [1:0] {
      TGT_NONE  = 2'd0,
      TGT_OCR   = 2'd1,
      TGT_START = 2'd2,
      TGT_CHAN  = 2'd3
   } tgt_e;

   typedef struct packed {
      tgt_e       tgt;
      logic [1:0] lane;
      logic [1:0] word;
   } dec_t;

   function automatic int lane_base_word(input int k);
      return FIRST_LANE_WORD + LANE_STRIDE_W * k;
   endfunction

   function automatic int lane_span(input int k);
      return (k == CAP_LANE) ? LANE_WORDS_CAP : LANE_WORDS_STD;
   endfunction

endpackage

// File: rtl/tmu_addr_dec.sv
module tmu_addr_dec
   import tmu_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int NCH     = 3,
   parameter bit HAS_OCR = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec,
   output logic [CH_MAX-1:0] lane_hit
);

   localparam int WW = ADDR_W - 2;

   logic [WW-1:0] widx;
   logic          aligned;
   logic [1:0]    lane_word [CH_MAX];

   assign widx    = addr[ADDR_W-1:2];
   assign aligned = (addr[1:0] == 2'b00);

   for (genvar k = 0; k < CH_MAX; k++) begin : g_lane
      localparam int BASE = lane_base_word(k);
      localparam int SPAN = lane_span(k);

      assign lane_word[k] = 2'(widx - WW'(BASE));

      if (k < NCH) begin : g_on
         assign lane_hit[k] = aligned
                            && (widx >= WW'(BASE))
                            && (widx <  WW'(BASE + SPAN));
      end else begin : g_off
         assign lane_hit[k] = 1'b0;
      end
   end

   always_comb begin
      dec = '0;
      if (aligned && HAS_OCR && (widx == WW'(OCR_WORD))) begin
         dec.tgt = TGT_OCR;
      end else if (aligned && (widx == WW'(START_WORD))) begin
         dec.tgt = TGT_START;
      end else begin
         for (int k = 0; k < CH_MAX; k++) begin
            if (lane_hit[k]) begin
               dec.tgt  = TGT_CHAN;
               dec.lane = 2'(k);
               dec.word = lane_word[k];
            end
         end
      end
   end

endmodule

// File: rtl/tmu_ctl_regs.sv
module tmu_ctl_regs
   import tmu_pkg::*;
#(
   parameter int NCH     = 3,
   parameter bit HAS_OCR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ocr,
   input  logic              wr_start,
   input  logic [CH_MAX-1:0] wbits,
   output logic              start_bad,
   output logic              ocr_q,
   output logic [CH_MAX-1:0] start_q
);

   localparam logic [CH_MAX-1:0] RUN_MASK = CH_MAX'((1 << NCH) - 1);

   logic ocr_en;

   // A write that sets a bit for an absent lane is rejected as a whole.
   assign start_bad = wr_start && ((wbits & ~RUN_MASK) != '0);
   assign ocr_en    = HAS_OCR && wr_ocr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
      end else if (wr_start && !start_bad) begin
         start_q <= wbits & RUN_MASK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ocr_q <= 1'b0;
      end else if (ocr_en) begin
         ocr_q <= wbits[0];
      end
   end

   a_r8_bad_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
      start_bad |=> $stable(start_q));

   a_r3_ocr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ocr |=> $stable(ocr_q));

   a_r4_start_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q & ~RUN_MASK) == '0);

endmodule

// File: rtl/tmu_rsp.sv
module tmu_rsp
   import tmu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  tgt_e                     tgt,
   input  logic [1:0]               lane,
   input  logic                     bad,
   input  logic                     ocr_q,
   input  logic [CH_MAX-1:0]        start_q,
   input  logic [CH_MAX*DATA_W-1:0] ch_rdata,
   output logic                     rsp_valid,
   output logic [DATA_W-1:0]        rsp_rdata,
   output logic                     rsp_err
);

   logic [DATA_W-1:0] lane_data [CH_MAX];
   logic [DATA_W-1:0] rd;
   logic              err_now;

   for (genvar k = 0; k < CH_MAX; k++) begin : g_slice
      assign lane_data[k] = ch_rdata[k*DATA_W +: DATA_W];
   end

   always_comb begin
      rd = '0;
      unique case (tgt)
         TGT_OCR:   rd = DATA_W'(ocr_q);
         TGT_START: rd = DATA_W'(start_q);
         TGT_CHAN: begin
            for (int k = 0; k < CH_MAX; k++) begin
               if (lane == 2'(k)) rd = lane_data[k];
            end
         end
         default:   rd = '0;
      endcase
   end

   assign err_now = (tgt == TGT_NONE) || bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && err_now;
         rsp_rdata <= (req_valid && !req_write && !err_now) ? rd : '0;
      end
   end

   a_r9_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == '0));

   a_r2_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_valid);

endmodule

// File: rtl/tmu_wrap.sv
module tmu_wrap
   import tmu_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter bit THREE_CH = 1'b1,
   parameter bit HAS_OCR  = 1'b1,
   parameter bit EXT_CLK  = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     rsp_valid,
   output logic [DATA_W-1:0]        rsp_rdata,
   output logic                     rsp_err,
   output logic                     out_ctl,
   output logic [CH_MAX-1:0]        ch_run,
   output logic [CH_MAX-1:0]        ch_sel,
   output logic                     ch_write,
   output logic [1:0]               ch_word,
   output logic [DATA_W-1:0]        ch_wdata,
   input  logic [CH_MAX*DATA_W-1:0] ch_rdata,
   input  logic [CH_MAX-1:0]        ch_irq,
   output logic [CH_MAX-1:0]        irq,
   output logic [CH_MAX-1:0]        ch_cap_en,
   output logic [CH_MAX-1:0]        ch_ext_clk
);

   localparam int NCH = THREE_CH ? CH_MAX : CH_MAX - 1;

   // Elaboration-time parameter checks.
   if (ADDR_W < 6) begin : g_chk_aw
      $error("tmu_wrap: ADDR_W must cover the last lane window");
   end
   if (DATA_W < CH_MAX) begin : g_chk_dw
      $error("tmu_wrap: DATA_W narrower than the run register");
   end

   dec_t              dec;
   logic [CH_MAX-1:0] lane_hit;
   logic              wr_any;
   logic              wr_ocr;
   logic              wr_start;
   logic              start_bad;
   logic              ocr_q;
   logic [CH_MAX-1:0] start_q;

   tmu_addr_dec #(
      .ADDR_W  (ADDR_W),
      .NCH     (NCH),
      .HAS_OCR (HAS_OCR)
   ) u_dec (
      .addr     (req_addr),
      .dec      (dec),
      .lane_hit (lane_hit)
   );

   assign wr_any   = req_valid && req_write;
   assign wr_ocr   = wr_any && (dec.tgt == TGT_OCR);
   assign wr_start = wr_any && (dec.tgt == TGT_START);

   tmu_ctl_regs #(
      .NCH     (NCH),
      .HAS_OCR (HAS_OCR)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ocr    (wr_ocr),
      .wr_start  (wr_start),
      .wbits     (req_wdata[CH_MAX-1:0]),
      .start_bad (start_bad),
      .ocr_q     (ocr_q),
      .start_q   (start_q)
   );

   tmu_rsp #(
      .DATA_W (DATA_W)
   ) u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .tgt       (dec.tgt),
      .lane      (dec.lane),
      .bad       (start_bad),
      .ocr_q     (ocr_q),
      .start_q   (start_q),
      .ch_rdata  (ch_rdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .rsp_err   (rsp_err)
   );

   assign ch_sel   = {CH_MAX{req_valid}} & lane_hit;
   assign ch_write = wr_any && (lane_hit != '0);
   assign ch_word  = dec.word;
   assign ch_wdata = req_wdata;
   assign ch_run   = start_q;
   assign out_ctl  = ocr_q;

   for (genvar k = 0; k < CH_MAX; k++) begin : g_strap
      if (k < NCH) begin : g_on
         assign irq[k]        = ch_irq[k];
         assign ch_ext_clk[k] = EXT_CLK;
         assign ch_cap_en[k]  = (k == CAP_LANE);
      end else begin : g_off
         assign irq[k]        = 1'b0;
         assign ch_ext_clk[k] = 1'b0;
         assign ch_cap_en[k]  = 1'b0;
      end
   end

   a_r5_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_sel));

   a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r9_lane_not_err: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (ch_sel != '0)) |=> !rsp_err);

   a_r4_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_any |=> $stable(ch_run));

   if (NCH < CH_MAX) begin : g_two_chk
      a_r7_no_lane2: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_sel[CAP_LANE] && !ch_run[CAP_LANE]);
   end

endmodule

// File: tb/tmu_wrap_tb.sv
`timescale 1ns/1ps
module tmu_wrap_tb;

   localparam int DW = 32;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [2:0]    ch_irq_t = '0;

   // Configuration A: three lanes, output-control present, external clock.
   logic          rsp_valid_a, rsp_err_a, out_ctl_a, chw_a;
   logic [DW-1:0] rsp_rdata_a, wdata_a;
   logic [2:0]    run_a, sel_a, irq_a, cap_a, ext_a;
   logic [1:0]    word_a;
   logic [3*DW-1:0] rdata_a;
   // Configuration B: two lanes, no output-control register.
   logic          rsp_valid_b, rsp_err_b, out_ctl_b, chw_b;
   logic [DW-1:0] rsp_rdata_b, wdata_b;
   logic [2:0]    run_b, sel_b, irq_b, cap_b, ext_b;
   logic [1:0]    word_b;
   logic [3*DW-1:0] rdata_b;

   int checks = 0;
   int fails  = 0;

   logic       m_ocr_a = 1'b0, m_ocr_b = 1'b0;
   logic [2:0] m_start_a = '0, m_start_b = '0;

   always #2 clk = ~clk;

   function automatic logic [DW-1:0] lane_val(input int k, input logic [1:0] w);
      return 32'h5A00_0000 | (DW'(k) << 16) | DW'(w);
   endfunction

   assign rdata_a = {lane_val(2, word_a), lane_val(1, word_a), lane_val(0, word_a)};
   assign rdata_b = {lane_val(2, word_b), lane_val(1, word_b), lane_val(0, word_b)};

   tmu_wrap #(.DATA_W(DW), .ADDR_W(AW), .THREE_CH(1'b1), .HAS_OCR(1'b1), .EXT_CLK(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid_a), .rsp_rdata(rsp_rdata_a), .rsp_err(rsp_err_a),
      .out_ctl(out_ctl_a), .ch_run(run_a), .ch_sel(sel_a), .ch_write(chw_a),
      .ch_word(word_a), .ch_wdata(wdata_a), .ch_rdata(rdata_a), .ch_irq(ch_irq_t),
      .irq(irq_a), .ch_cap_en(cap_a), .ch_ext_clk(ext_a));

   tmu_wrap #(.DATA_W(DW), .ADDR_W(AW), .THREE_CH(1'b0), .HAS_OCR(1'b0), .EXT_CLK(1'b0)) u_dut_two (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid_b), .rsp_rdata(rsp_rdata_b), .rsp_err(rsp_err_b),
      .out_ctl(out_ctl_b), .ch_run(run_b), .ch_sel(sel_b), .ch_write(chw_b),
      .ch_word(word_b), .ch_wdata(wdata_b), .ch_rdata(rdata_b), .ch_irq(ch_irq_t),
      .irq(irq_b), .ch_cap_en(cap_b), .ch_ext_clk(ext_b));

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // kind: 0 invalid, 1 output-control, 2 run register, 3 lane window
   task automatic predict(input logic [AW-1:0] a, input bit three, input bit has_ocr,
                          output int kind, output int lane, output int word);
      int w;
      kind = 0; lane = 0; word = 0;
      w = int'(a >> 2);
      if (a[1:0] == 2'b00) begin
         if (w == 0 && has_ocr)            kind = 1;
         else if (w == 1)                  kind = 2;
         else if (w >= 2 && w <= 4)        begin kind = 3; lane = 0; word = w - 2; end
         else if (w >= 5 && w <= 7)        begin kind = 3; lane = 1; word = w - 5; end
         else if (w >= 8 && w <= 11 && three) begin kind = 3; lane = 2; word = w - 8; end
      end
   endtask

   function automatic string tag(input int kind, input bit three, input logic [AW-1:0] a,
                                 input bit wr, input logic [DW-1:0] d);
      if (kind == 2 && wr && !three && d[2]) return "R8";
      if (kind == 0 && !three && a >= 8'h20) return "R7";
      case (kind)
         1: return "R3";
         2: return "R4";
         3: return "R5";
         default: return "R9";
      endcase
   endfunction

   task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      int ka, la, wa, kb, lb, wb;
      string ta, tb;
      logic eb;
      logic [DW-1:0] xa, xb;
      predict(a, 1'b1, 1'b1, ka, la, wa);
      predict(a, 1'b0, 1'b0, kb, lb, wb);
      ta = tag(ka, 1'b1, a, wr, d);
      tb = tag(kb, 1'b0, a, wr, d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      #1;
      chk({ta, " sel A"}, DW'(sel_a), (ka == 3) ? DW'(1 << la) : '0);
      chk({tb, " sel B"}, DW'(sel_b), (kb == 3) ? DW'(1 << lb) : '0);
      chk({ta, " ch_write A"}, DW'(chw_a), DW'(wr && ka == 3));
      chk({tb, " ch_write B"}, DW'(chw_b), DW'(wr && kb == 3));
      if (ka == 3) chk("R5 word A", DW'(word_a), DW'(wa));
      if (kb == 3) chk("R5 word B", DW'(word_b), DW'(wb));
      if (wr && ka == 3) chk("R5 wdata A", wdata_a, d);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      eb = (kb == 0) || (kb == 2 && wr && d[2]);
      xa = '0; xb = '0;
      if (!wr) begin
         case (ka)
            1: xa = DW'(m_ocr_a);
            2: xa = DW'(m_start_a);
            3: xa = lane_val(la, 2'(wa));
            default: xa = '0;
         endcase
         case (kb)
            2: xb = DW'(m_start_b);
            3: xb = lane_val(lb, 2'(wb));
            default: xb = '0;
         endcase
      end
      chk("R2 rsp_valid A", DW'(rsp_valid_a), 1);
      chk("R2 rsp_valid B", DW'(rsp_valid_b), 1);
      chk({ta, " rsp_err A"}, DW'(rsp_err_a), DW'(ka == 0));
      chk({tb, " rsp_err B"}, DW'(rsp_err_b), DW'(eb));
      chk({ta, " rdata A"}, rsp_rdata_a, xa);
      chk({tb, " rdata B"}, rsp_rdata_b, xb);
      if (wr) begin
         if (ka == 1) m_ocr_a = d[0];
         if (ka == 2) m_start_a = d[2:0];
         if (kb == 2 && !d[2]) m_start_b = {1'b0, d[1:0]};
      end
      chk({ta, " run A"}, DW'(run_a), DW'(m_start_a));
      chk({tb, " run B"}, DW'(run_b), DW'(m_start_b));
      chk("R3 out_ctl A", DW'(out_ctl_a), DW'(m_ocr_a));
      chk("R3 out_ctl B", DW'(out_ctl_b), 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rsp_valid A", DW'(rsp_valid_a), 0);
      chk("R1 rsp_valid B", DW'(rsp_valid_b), 0);
      chk("R1 rsp_err A", DW'(rsp_err_a), 0);
      chk("R1 rdata A", rsp_rdata_a, 0);
      chk("R1 run A", DW'(run_a), 0);
      chk("R1 run B", DW'(run_b), 0);
      chk("R1 out_ctl A", DW'(out_ctl_a), 0);

      // R6 and R10 straps and interrupt routing
      chk("R6 cap A", DW'(cap_a), 3'b100);
      chk("R6 cap B", DW'(cap_b), 3'b000);
      chk("R6 ext A", DW'(ext_a), 3'b111);
      chk("R6 ext B", DW'(ext_b), 3'b000);
      ch_irq_t = 3'b101; #1;
      chk("R10 irq A", DW'(irq_a), 3'b101);
      chk("R10 irq B", DW'(irq_b), 3'b001);
      ch_irq_t = 3'b110; #1;
      chk("R10 irq A", DW'(irq_a), 3'b110);
      chk("R10 irq B", DW'(irq_b), 3'b010);

      // Read sweep over every address
      for (int a = 0; a < (1 << AW); a++) access(1'b0, AW'(a), '0);

      // Write sweep over every address
      for (int a = 0; a < (1 << AW); a++) access(1'b1, AW'(a), {4{~8'(a)}});

      // Run register corners, R4 and R8
      access(1'b1, 8'h04, 32'h0000_0007);
      access(1'b0, 8'h04, '0);
      access(1'b1, 8'h04, 32'h0000_0005);
      access(1'b1, 8'h04, 32'hFFFF_FFFA);
      access(1'b0, 8'h04, '0);
      access(1'b1, 8'h04, 32'h0000_0000);
      access(1'b0, 8'h04, '0);

      // Output-control register, R3
      access(1'b1, 8'h00, 32'hFFFF_FFFE);
      access(1'b0, 8'h00, '0);
      access(1'b1, 8'h00, 32'h0000_0001);
      access(1'b0, 8'h00, '0);

      // Capture word of lane 2, R5 and R7
      access(1'b1, 8'h2C, 32'h1234_5678);
      access(1'b0, 8'h2C, '0);

      // Idle cycle: no response without a request, R2
      @(negedge clk);
      chk("R2 idle A", DW'(rsp_valid_a), 0);
      chk("R2 idle B", DW'(rsp_valid_b), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule